// File: doc/BRIEF.md
# Multi-Channel Cell Link SPI Exchanger

This block drives a bank of point-to-point SPI master links, one dedicated link for each converter cell in a star arrangement. Once per control period the controller raises a start pulse. All links then run in lockstep. Each link sends a fresh 16-bit PWM setpoint to its cell and collects that cell's 16-bit ADC reading. The captured readings of all cells appear at the output together.

There are two link modes, chosen at each start. In the combined mode the chip select is active low for a single 16-clock frame, and in that frame MOSI and MISO shift at the same time. In the split mode one select wire serves two devices at its two levels. Driving it low addresses the cell's ADC, and the reading is clocked in first. Driving it high addresses the cell controller, which then receives the setpoint. An idle bit period lies between the two phases. A free-running PWM timing clock is also sent down every link.

Top module: `cellx_bank`

## Requirements
- R1: While reset is held and after release, every select line is high and every SCLK and MOSI line is low. done_o and overrun_o are low and adc_o is all zeros.
- R2: A start_i pulse accepted while idle latches the setpoints of all channels. Channel g occupies bits [g*16 +: 16] of setpoint_i and adc_o. All links share identical SCLK and select waveforms. A change of setpoint_i after the start has no effect on the words sent.
- R3: Combined mode (split_i=0 at start) follows a fixed schedule, where H = HALF_DIV clock cycles. Select goes low on the clock after the start. SCLK stays low for H cycles, then gives 16 periods of H low and H high. SCLK is then low for H cycles, after which select returns high. The whole frame is 34*H cycles.
- R4: SPI mode 0 is used, MSB first. MOSI changes only while SCLK is low and never during an SCLK high half. MISO is sampled at each rising SCLK edge.
- R5: In combined mode each channel transmits its own latched setpoint during the frame and captures the 16 bits its cell returns.
- R6: Split mode (split_i=1 at start) has two phases. First, select is low for 34*H cycles with 16 SCLK periods, and MOSI is held at 0 while the ADC word is read. Next, select is high with SCLK low for 2*H cycles. Then come 16 SCLK periods carrying the setpoint, followed by H cycles with SCLK low, for a total of 69*H cycles. MISO during the high-select phase is ignored.
- R7: At the end of a transfer, adc_o for all channels and done_o change on the same clock. done_o then stays high until the next accepted start, which clears it. adc_o does not change at any other time.
- R8: A start_i pulse while a transfer is running neither restarts nor alters that transfer. It sets overrun_o, which stays high until reset.
- R9: pwm_clk_o is a free-running clock that is identical on all links. It starts low out of reset and toggles every PWM_HALF clock cycles, whatever the transfers are doing.
- R10: The mode is taken from split_i at the accepted start. Changing split_i during a transfer does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer on all links |
| split_i | input | 1 | Mode for the next transfer: 0 combined, 1 split select |
| setpoint_i | input | NUM_CH*WORD_W | PWM setpoints, channel g at [g*WORD_W +: WORD_W] |
| miso_i | input | NUM_CH | Serial data from each cell |
| sclk_o | output | NUM_CH | Serial clock for each link |
| mosi_o | output | NUM_CH | Serial data toward each cell |
| sel_o | output | NUM_CH | Select line for each link, rests high |
| pwm_clk_o | output | NUM_CH | PWM timing clock for each cell |
| adc_o | output | NUM_CH*WORD_W | Captured ADC words, channel g at [g*WORD_W +: WORD_W] |
| done_o | output | 1 | High from the end of a transfer until the next accepted start |
| overrun_o | output | 1 | Sticky flag for a start that arrived while busy |

## Verification
A fault in the shared sequencer's counters shows up on the clock where it happens. It moves an SCLK or select edge away from the cycle the schedule predicts, and the bench compares the schedule on every clock. A fault in a channel's shift register only becomes visible when that channel's word is examined. A corrupted setpoint bit appears on MOSI within one SCLK period and in the word the cell model captures at the end of the frame. A corrupted capture appears on adc_o on the clock that done_o rises. A lost mode latch or a faulty overrun flag changes the frame length or the flag within a cycle of the stray input.

// File: rtl/cellx_pkg.sv
package cellx_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_SHIFT,
        SEQ_HOLD,
        SEQ_GAP
    } seq_state_e;

endpackage

// File: rtl/cellx_seq.sv
// Shared timing engine: one schedule drives every link in lockstep.
module cellx_seq
    import cellx_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int WORD_W   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic split,
    output logic busy,
    output logic sclk,
    output logic sel,
    output logic rx_en,
    output logic tx_en,
    output logic load,
    output logic rise,
    output logic fall,
    output logic finish,
    output logic done,
    output logic overrun
);
    localparam int CNT_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int HALVES = 2 * WORD_W;
    localparam int HIDX_W = $clog2(HALVES);
    localparam logic [CNT_W-1:0]  CNT_TOP   = CNT_W'(HALF_DIV - 1);
    localparam logic [HIDX_W-1:0] HIDX_LAST = HIDX_W'(HALVES - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [HIDX_W-1:0]  hidx;
        logic               phase;
        logic               split;
        logic               sclk;
        logic               sel;
        logic               done;
        logic               ovr;
    } seq_t;

    seq_t s_q, s_d;
    logic tick;

    always_comb begin
        s_d    = s_q;
        load   = 1'b0;
        rise   = 1'b0;
        fall   = 1'b0;
        finish = 1'b0;
        tick   = (s_q.cnt == '0);
        if (!tick) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (start && (s_q.st != SEQ_IDLE)) begin
            s_d.ovr = 1'b1;
        end
        case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    load      = 1'b1;
                    s_d.st    = SEQ_SETUP;
                    s_d.cnt   = CNT_TOP;
                    s_d.hidx  = '0;
                    s_d.sel   = 1'b0;
                    s_d.phase = 1'b0;
                    s_d.split = split;
                    s_d.done  = 1'b0;
                end
            end
            SEQ_SETUP: begin
                if (tick) begin
                    s_d.st   = SEQ_SHIFT;
                    s_d.cnt  = CNT_TOP;
                    s_d.hidx = '0;
                end
            end
            SEQ_SHIFT: begin
                if (tick) begin
                    s_d.cnt = CNT_TOP;
                    if (s_q.hidx == HIDX_LAST) begin
                        s_d.st   = SEQ_HOLD;
                        s_d.sclk = 1'b0;
                    end else begin
                        s_d.hidx = s_q.hidx + 1'b1;
                        if (!s_q.hidx[0]) begin
                            s_d.sclk = 1'b1;
                            rise     = 1'b1;
                        end else begin
                            s_d.sclk = 1'b0;
                            fall     = 1'b1;
                        end
                    end
                end
            end
            SEQ_HOLD: begin
                if (tick) begin
                    if (s_q.split && !s_q.phase) begin
                        s_d.st    = SEQ_GAP;
                        s_d.cnt   = CNT_TOP;
                        s_d.hidx  = '0;
                        s_d.sel   = 1'b1;
                        s_d.phase = 1'b1;
                    end else begin
                        s_d.st   = SEQ_IDLE;
                        s_d.sel  = 1'b1;
                        s_d.done = 1'b1;
                        finish   = 1'b1;
                    end
                end
            end
            SEQ_GAP: begin
                if (tick) begin
                    s_d.cnt = CNT_TOP;
                    if (s_q.hidx[0]) begin
                        s_d.st   = SEQ_SHIFT;
                        s_d.hidx = '0;
                    end else begin
                        s_d.hidx = HIDX_W'(1);
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= SEQ_IDLE;
            s_q.cnt   <= '0;
            s_q.hidx  <= '0;
            s_q.phase <= 1'b0;
            s_q.split <= 1'b0;
            s_q.sclk  <= 1'b0;
            s_q.sel   <= 1'b1;
            s_q.done  <= 1'b0;
            s_q.ovr   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st != SEQ_IDLE);
    assign sclk    = s_q.sclk;
    assign sel     = s_q.sel;
    assign done    = s_q.done;
    assign overrun = s_q.ovr;
    assign rx_en   = !s_q.split || !s_q.phase;
    assign tx_en   = !s_q.split || s_q.phase;

endmodule

// File: rtl/cellx_lane.sv
// One link's data path: setpoint shifter, reading shifter, result register.
module cellx_lane #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] setpoint,
    input  logic              shift_tx,
    input  logic              sample_rx,
    input  logic              commit,
    input  logic              drive,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] adc
);
    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] adc;
    } lane_t;

    lane_t l_q, l_d;

    always_comb begin
        l_d = l_q;
        if (load) begin
            l_d.tx = setpoint;
        end else if (shift_tx) begin
            l_d.tx = {l_q.tx[WORD_W-2:0], 1'b0};
        end
        if (sample_rx) begin
            l_d.rx = {l_q.rx[WORD_W-2:0], miso};
        end
        if (commit) begin
            l_d.adc = l_q.rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign mosi = drive ? l_q.tx[WORD_W-1] : 1'b0;
    assign adc  = l_q.adc;

endmodule

// File: rtl/cellx_pwmdiv.sv
// Free-running divided clock sent to the cells for PWM timing.
module cellx_pwmdiv #(
    parameter int PWM_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwm_clk
);
    localparam int CW = (PWM_HALF > 1) ? $clog2(PWM_HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(PWM_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t d_q, d_d;

    always_comb begin
        d_d = d_q;
        if (d_q.cnt == CNT_TOP) begin
            d_d.cnt = '0;
            d_d.lvl = !d_q.lvl;
        end else begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign pwm_clk = d_q.lvl;

endmodule

// File: rtl/cellx_bank.sv
// Bank of per-cell SPI links started together once per control period.
module cellx_bank #(
    parameter int NUM_CH   = 32,
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 4,
    parameter int PWM_HALF = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     split_i,
    input  logic [NUM_CH*WORD_W-1:0] setpoint_i,
    input  logic [NUM_CH-1:0]        miso_i,
    output logic [NUM_CH-1:0]        sclk_o,
    output logic [NUM_CH-1:0]        mosi_o,
    output logic [NUM_CH-1:0]        sel_o,
    output logic [NUM_CH-1:0]        pwm_clk_o,
    output logic [NUM_CH*WORD_W-1:0] adc_o,
    output logic                     done_o,
    output logic                     overrun_o
);
    logic seq_busy;
    logic seq_sclk;
    logic seq_sel;
    logic seq_rx_en;
    logic seq_tx_en;
    logic seq_load;
    logic seq_rise;
    logic seq_fall;
    logic seq_finish;
    logic pwm_lvl;
    logic lane_shift;
    logic lane_sample;
    logic lane_drive;

    cellx_seq #(
        .HALF_DIV (HALF_DIV),
        .WORD_W   (WORD_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .split   (split_i),
        .busy    (seq_busy),
        .sclk    (seq_sclk),
        .sel     (seq_sel),
        .rx_en   (seq_rx_en),
        .tx_en   (seq_tx_en),
        .load    (seq_load),
        .rise    (seq_rise),
        .fall    (seq_fall),
        .finish  (seq_finish),
        .done    (done_o),
        .overrun (overrun_o)
    );

    cellx_pwmdiv #(
        .PWM_HALF (PWM_HALF)
    ) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_clk (pwm_lvl)
    );

    assign lane_shift  = seq_fall && seq_tx_en;
    assign lane_sample = seq_rise && seq_rx_en;
    assign lane_drive  = seq_busy && seq_tx_en;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        cellx_lane #(
            .WORD_W (WORD_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (seq_load),
            .setpoint  (setpoint_i[g*WORD_W +: WORD_W]),
            .shift_tx  (lane_shift),
            .sample_rx (lane_sample),
            .commit    (seq_finish),
            .drive     (lane_drive),
            .miso      (miso_i[g]),
            .mosi      (mosi_o[g]),
            .adc       (adc_o[g*WORD_W +: WORD_W])
        );
        assign sclk_o[g]    = seq_sclk;
        assign sel_o[g]     = seq_sel;
        assign pwm_clk_o[g] = pwm_lvl;
    end

endmodule

// File: rtl/cellx_bank_chk.sv
module cellx_bank_chk #(
    parameter int NUM_CH = 32,
    parameter int WORD_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     seq_busy,
    input logic [NUM_CH-1:0]        sclk_o,
    input logic [NUM_CH-1:0]        mosi_o,
    input logic [NUM_CH-1:0]        sel_o,
    input logic [NUM_CH-1:0]        pwm_clk_o,
    input logic [NUM_CH*WORD_W-1:0] adc_o,
    input logic                     done_o,
    input logic                     overrun_o
);
    // R2
    lanes_sclk_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o == '0) || (sclk_o == '1));

    // R2
    lanes_sel_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0) || (sel_o == '1));

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o[0] && $past(sclk_o[0])) |-> $stable(mosi_o));

    // R3
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> ((sclk_o == '0) && (sel_o == '1) && (mosi_o == '0)));

    // R7
    adc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> $stable(adc_o));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !done_o);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun_o) |-> overrun_o);

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && seq_busy) |=> overrun_o);

    // R9
    pwm_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_clk_o == '0) || (pwm_clk_o == '1));

endmodule

bind cellx_bank cellx_bank_chk #(
    .NUM_CH (NUM_CH),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .seq_busy  (seq_busy),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .sel_o     (sel_o),
    .pwm_clk_o (pwm_clk_o),
    .adc_o     (adc_o),
    .done_o    (done_o),
    .overrun_o (overrun_o)
);

// File: tb/tb_cellx_bank.sv
`timescale 1ns/1ps
module tb_cellx_bank;
    localparam int NUM_CH   = 32;
    localparam int WORD_W   = 16;
    localparam int HALF_DIV = 4;
    localparam int PWM_HALF = 10;
    localparam int BUS_W    = NUM_CH * WORD_W;
    localparam int H        = HALF_DIV;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              split_i = 1'b0;
    logic [BUS_W-1:0]  setpoint_i = '0;
    logic [NUM_CH-1:0] miso_i = '0;
    logic [NUM_CH-1:0] sclk_o, mosi_o, sel_o, pwm_clk_o;
    logic [BUS_W-1:0]  adc_o;
    logic              done_o, overrun_o;

    always #2.5 clk = ~clk;

    cellx_bank #(
        .NUM_CH (NUM_CH), .WORD_W (WORD_W), .HALF_DIV (HALF_DIV), .PWM_HALF (PWM_HALF)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .split_i (split_i),
        .setpoint_i (setpoint_i), .miso_i (miso_i), .sclk_o (sclk_o),
        .mosi_o (mosi_o), .sel_o (sel_o), .pwm_clk_o (pwm_clk_o),
        .adc_o (adc_o), .done_o (done_o), .overrun_o (overrun_o)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: position in the frame schedule.
    bit               m_busy = 0, m_split = 0, m_done = 0, m_ovr = 0;
    int               m_k = 0, m_len = 0, m_n = 0;
    logic [WORD_W-1:0] m_sp [NUM_CH];
    logic [WORD_W-1:0] adc_word [NUM_CH];
    logic [WORD_W-1:0] exp_sp [NUM_CH];
    logic [WORD_W-1:0] cap [NUM_CH];
    logic [BUS_W-1:0]  m_adc = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ovr = 0; m_n = 0; m_adc = '0;
        end else begin
            m_n++;
            if (m_busy) begin
                if (start_i) m_ovr = 1;
                m_k++;
                if (m_k == m_len) begin
                    m_busy = 0;
                    m_done = 1;
                    for (int g = 0; g < NUM_CH; g++) m_adc[g*WORD_W +: WORD_W] = adc_word[g];
                end
            end else if (start_i) begin
                m_busy  = 1;
                m_k     = 0;
                m_split = split_i;
                m_len   = split_i ? 69 * H : 34 * H;
                m_done  = 0;
                for (int g = 0; g < NUM_CH; g++) m_sp[g] = setpoint_i[g*WORD_W +: WORD_W];
            end
        end
    end

    // Frame segment: setup H, 32 halves, hold H.
    task automatic seg(input int k, output logic sck, output int b);
        int half;
        if (k < H) begin
            sck = 1'b0; b = WORD_W - 1;
        end else if (k < 33 * H) begin
            half = (k - H) / H;
            sck  = (half % 2) == 1;
            b    = WORD_W - 1 - half / 2;
        end else begin
            sck = 1'b0; b = 0;
        end
    endtask

    logic prev_sclk = 1'b0, prev_sel = 1'b1, noise = 1'b0;
    int   nfall = 0;

    always @(negedge clk) begin
        logic es, esel, epwm;
        int   b;
        logic [NUM_CH-1:0] em;
        // cell models: ADC shifts on falling SCLK, controller samples on rising
        if (prev_sel && !sel_o[0]) nfall = 0;
        else if (prev_sclk && !sclk_o[0]) begin
            if (!sel_o[0]) nfall++;
            else noise = ~noise;
        end
        if (!prev_sclk && sclk_o[0]) begin
            for (int g = 0; g < NUM_CH; g++)
                if ((m_split && sel_o[g]) || (!m_split && !sel_o[g]))
                    cap[g] = {cap[g][WORD_W-2:0], mosi_o[g]};
        end
        for (int g = 0; g < NUM_CH; g++) begin
            if (!sel_o[0]) miso_i[g] = (nfall < WORD_W) ? adc_word[g][WORD_W-1-nfall] : 1'b0;
            else           miso_i[g] = noise ^ g[0];
        end
        prev_sclk = sclk_o[0];
        prev_sel  = sel_o[0];

        // expected lines for this cycle
        if (!m_busy) begin
            es = 1'b0; esel = 1'b1; b = -1;
        end else if (m_k < 34 * H) begin
            esel = 1'b0;
            seg(m_k, es, b);
            if (m_split) b = -1;
        end else begin
            esel = 1'b1;
            seg(m_k - 35 * H, es, b);
        end
        for (int g = 0; g < NUM_CH; g++) em[g] = (b < 0) ? 1'b0 : m_sp[g][b];
        epwm = ((m_n / PWM_HALF) % 2) == 1;

        check(sclk_o === {NUM_CH{es}}, m_split ? "R6 sclk" : "R3 sclk",
              BUS_W'(sclk_o), BUS_W'({NUM_CH{es}}));
        check(sel_o === {NUM_CH{esel}}, m_split ? "R6 sel" : "R3 sel",
              BUS_W'(sel_o), BUS_W'({NUM_CH{esel}}));
        check(mosi_o === em, "R4 mosi", BUS_W'(mosi_o), BUS_W'(em));
        check(done_o === m_done, "R7 done", BUS_W'(done_o), BUS_W'(m_done));
        check(adc_o === m_adc, "R7 adc timing", adc_o, m_adc);
        check(overrun_o === m_ovr, "R8 overrun", BUS_W'(overrun_o), BUS_W'(m_ovr));
        check(pwm_clk_o === {NUM_CH{epwm}}, "R9 pwm", BUS_W'(pwm_clk_o), BUS_W'({NUM_CH{epwm}}));
    end

    task automatic set_words(input int kind, input int seed);
        for (int g = 0; g < NUM_CH; g++) begin
            case (kind)
                1: begin setpoint_i[g*WORD_W +: WORD_W] = '1; adc_word[g] = '0; end
                2: begin setpoint_i[g*WORD_W +: WORD_W] = '0; adc_word[g] = '1; end
                default: begin
                    setpoint_i[g*WORD_W +: WORD_W] = WORD_W'(((g + 1) * 1111 + seed * 4099) ^ (g << 9));
                    adc_word[g] = WORD_W'(~((g + 3) * 2329 + seed * 733));
                end
            endcase
        end
    endtask

    task automatic run(input bit mode, input bit flip, input bit poke, input string tag);
        int n;
        @(negedge clk);
        split_i = mode;
        start_i = 1'b1;
        for (int g = 0; g < NUM_CH; g++) exp_sp[g] = setpoint_i[g*WORD_W +: WORD_W];
        @(negedge clk);
        start_i = 1'b0;
        setpoint_i = ~setpoint_i;
        if (flip) begin
            repeat (10) @(negedge clk);
            split_i = ~split_i;
        end
        if (poke) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(done_o === 1'b1, tag, BUS_W'(done_o), BUS_W'(1));
        for (int g = 0; g < NUM_CH; g++) begin
            check(cap[g] === exp_sp[g], tag, BUS_W'(cap[g]), BUS_W'(exp_sp[g]));
            check(adc_o[g*WORD_W +: WORD_W] === adc_word[g], tag,
                  BUS_W'(adc_o[g*WORD_W +: WORD_W]), BUS_W'(adc_word[g]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sel_o === '1, "R1 sel", BUS_W'(sel_o), BUS_W'({NUM_CH{1'b1}}));
        check(sclk_o === '0 && mosi_o === '0, "R1 sclk/mosi", BUS_W'({sclk_o, mosi_o}), '0);
        check(!done_o && !overrun_o, "R1 flags", BUS_W'({done_o, overrun_o}), '0);
        check(adc_o === '0, "R1 adc", adc_o, '0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        set_words(0, 1); run(1'b0, 1'b0, 1'b0, "R2 latch");
        set_words(1, 0); run(1'b0, 1'b0, 1'b0, "R5 ones");
        set_words(0, 2); run(1'b0, 1'b0, 1'b0, "R5 pattern");
        set_words(0, 3); run(1'b1, 1'b0, 1'b0, "R6 pattern");
        set_words(2, 0); run(1'b1, 1'b0, 1'b0, "R6 zeros");
        repeat (7) @(negedge clk);
        check(done_o === 1'b1, "R7 done held", BUS_W'(done_o), BUS_W'(1));
        set_words(0, 4); run(1'b1, 1'b1, 1'b0, "R10 split");
        set_words(0, 5); run(1'b0, 1'b1, 1'b0, "R10 combined");
        set_words(0, 6); run(1'b0, 1'b0, 1'b1, "R8 poke");
        check(overrun_o === 1'b1, "R8 sticky", BUS_W'(overrun_o), BUS_W'(1));
        set_words(0, 7); run(1'b1, 1'b0, 1'b1, "R8 poke split");
        set_words(0, 8); run(1'b0, 1'b0, 1'b0, "R7 back to back");
        repeat (50) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule